// File: doc/BRIEF.md
# Split-Register Double-Precision Arithmetic Unit

This block holds a signed double-length integer in two registers, A and B, and changes it by loading, adding, subtracting or multiplying. The packed value is a two's complement number of 2·W−1 bits (31 bits at the default W = 16). Its top bit is the top bit of A. Below it come the low W−1 bits of A, then the low W−1 bits of B. The top bit of B sits outside the number. Arithmetic carries run from B's low field straight into A's low field and pass over that spare bit.

A caller gives a one-cycle `start` with a 2-bit opcode. It then offers memory words on `mem_word`, each one qualified by `mem_valid`. Double-length operations take two words, the high word first. Multiply takes a single word. The result appears on `a_out`/`b_out` in the cycle where `done` pulses.

The controller has seven states:
- IDLE waits for `start`.
- GET_HI takes the first word. On multiply it moves to MUL_RUN; on any other opcode it moves to GET_LO.
- GET_LO takes the second word and moves to COMBINE.
- COMBINE writes the result of load, add or subtract and moves to FINISH.
- MUL_RUN performs one shift-add step per cycle. After W−1 steps it moves to MUL_FIX.
- MUL_FIX applies the sign to the product, writes A:B and moves to FINISH.
- FINISH raises `done` for one cycle and returns to IDLE.

Top module: `dpa_core`

## Requirements
- R1: After reset, `a_out` and `b_out` are zero, and `ovf` and `done` are low.
- R2: Opcode 2'b00 (load) copies the first word into A and the second word into B exactly as received, top bit of B included.
- R3: Opcode 2'b01 (add) makes A:B the sum, modulo 2^(2W−1), of the packed register value {A, B[W−2:0]} and the packed operand {first word, second word[W−2:0]}. The top bits of the old B and of the second word have no effect. The top bit of the new B is 0.
- R4: Opcode 2'b10 (subtract) makes A:B the packed register value minus the packed operand. It uses the same packing, and the top bit of the new B is 0.
- R5: After add or subtract, `ovf` is 1 exactly when the true signed result lies outside the 2W−1-bit two's complement range. Load and multiply leave `ovf` at 0.
- R6: Opcode 2'b11 (multiply) takes the old A and the one operand word as W-bit two's complement numbers. The magnitude of each, taken modulo 2^(W−1), is multiplied. The product is negated when exactly one operand is negative and is written as a packed value. The top bit of the new B is 0.
- R7: `done` is a single-cycle pulse. For load, add and subtract it is visible 3 clock cycles after the edge that accepts the first word is driven. For multiply it is visible W+1 cycles after that edge.
- R8: `mem_valid` while waiting for `start`, and `start` while an operation is running, change neither A, B nor the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only in IDLE |
| op_sel | input | 2 | Opcode: 00 load, 01 add, 10 subtract, 11 multiply |
| mem_valid | input | 1 | `mem_word` carries an operand word this cycle |
| mem_word | input | W | Operand word from memory |
| a_out | output | W | A register (sign and high magnitude field) |
| b_out | output | W | B register (spare top bit and low magnitude field) |
| ovf | output | 1 | Overflow of the last add or subtract |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with W = 4. The packed value is then 7 bits, and multiply operands range from −8 to 7. At that size, every A:B bit pattern can be loaded. Every multiply operand pair can be tried. The add and subtract sweeps cover all 128 operand values against a strided set of register values, with the spare B bits toggled along the way. This brings every carry across the skipped bit, every overflow boundary and the magnitude-wrap case of −8 within reach. Expected results, flags and latencies are computed with plain integer arithmetic.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_MUL  = 2'b11
    } dpa_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_HI,
        ST_GET_LO,
        ST_COMBINE,
        ST_MUL_RUN,
        ST_MUL_FIX,
        ST_FINISH
    } dpa_state_e;

endpackage

// File: rtl/dpa_addsub.sv
module dpa_addsub #(
    parameter int VW = 31
) (
    input  logic [VW-1:0] x,
    input  logic [VW-1:0] y,
    input  logic          sub,
    output logic [VW-1:0] res,
    output logic          ovf
);
    logic [VW-1:0] y_eff;
    logic          cin;

    always_comb begin
        y_eff = sub ? ~y : y;
        cin   = sub;
        res   = x + y_eff + {{(VW-1){1'b0}}, cin};
        ovf   = (x[VW-1] == y_eff[VW-1]) && (res[VW-1] != x[VW-1]);
    end
endmodule

// File: rtl/dpa_signmag.sv
module dpa_signmag #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-2:0] lhs_mag,
    output logic [W-2:0] rhs_mag,
    output logic         neg
);
    localparam int FLD = W - 1;

    logic [W-1:0] lhs_abs;
    logic [W-1:0] rhs_abs;

    always_comb begin
        lhs_abs = lhs[W-1] ? (~lhs + {{FLD{1'b0}}, 1'b1}) : lhs;
        rhs_abs = rhs[W-1] ? (~rhs + {{FLD{1'b0}}, 1'b1}) : rhs;
        lhs_mag = lhs_abs[FLD-1:0];
        rhs_mag = rhs_abs[FLD-1:0];
        neg     = lhs[W-1] ^ rhs[W-1];
    end
endmodule

// File: rtl/dpa_mul_seq.sv
module dpa_mul_seq #(
    parameter int FLD = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [FLD-1:0] mcand,
    input  logic [FLD-1:0] mplier,
    input  logic           step,
    output logic [2*FLD-1:0] prod,
    output logic           last
);
    localparam int PW = 2 * FLD;
    localparam int CW = $clog2(FLD + 1);

    logic [PW-1:0]  acc_q;
    logic [PW-1:0]  mc_q;
    logic [FLD-1:0] mp_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            mc_q  <= {{FLD{1'b0}}, mcand};
            mp_q  <= mplier;
            cnt_q <= '0;
        end else if (step) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign prod = acc_q;
    assign last = (cnt_q == CW'(FLD - 1));

    // R6
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q < CW'(FLD)));
endmodule

// File: rtl/dpa_core.sv
module dpa_core
    import dpa_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic              mem_valid,
    input  logic [HALF_W-1:0] mem_word,
    output logic [HALF_W-1:0] a_out,
    output logic [HALF_W-1:0] b_out,
    output logic              ovf,
    output logic              done
);
    localparam int FLD = HALF_W - 1;
    localparam int VW  = 2 * HALF_W - 1;
    localparam int PW  = 2 * FLD;

    dpa_state_e state_q, state_d;
    dpa_op_e    op_q;

    logic [HALF_W-1:0] a_q, b_q, hi_q, lo_q;
    logic              ovf_q, neg_q;

    logic accept_start, cap_hi, cap_lo, wr_combine, mul_load, mul_step, wr_mul;

    logic [VW-1:0]  reg_val, opnd_val, as_res, mul_res;
    logic           as_ovf;
    logic [FLD-1:0] mag_a, mag_m;
    logic           mul_neg;
    logic [PW-1:0]  prod;
    logic           mul_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_GET_HI;
            ST_GET_HI:  if (mem_valid) state_d = (op_q == OP_MUL) ? ST_MUL_RUN : ST_GET_LO;
            ST_GET_LO:  if (mem_valid) state_d = ST_COMBINE;
            ST_COMBINE: state_d = ST_FINISH;
            ST_MUL_RUN: if (mul_last) state_d = ST_MUL_FIX;
            ST_MUL_FIX: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        accept_start = 1'b0;
        cap_hi       = 1'b0;
        cap_lo       = 1'b0;
        wr_combine   = 1'b0;
        mul_load     = 1'b0;
        mul_step     = 1'b0;
        wr_mul       = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept_start = start;
            ST_GET_HI: begin
                cap_hi   = mem_valid;
                mul_load = mem_valid && (op_q == OP_MUL);
            end
            ST_GET_LO:  cap_lo     = mem_valid;
            ST_COMBINE: wr_combine = 1'b1;
            ST_MUL_RUN: mul_step   = 1'b1;
            ST_MUL_FIX: wr_mul     = 1'b1;
            ST_FINISH:  done       = 1'b1;
            default:    done       = 1'b0;
        endcase
    end

    // Packed operands: carry skips the spare top bit of B
    assign reg_val  = {a_q,  b_q[FLD-1:0]};
    assign opnd_val = {hi_q, lo_q[FLD-1:0]};

    dpa_addsub #(.VW(VW)) i_addsub (
        .x   (reg_val),
        .y   (opnd_val),
        .sub (op_q == OP_SUB),
        .res (as_res),
        .ovf (as_ovf)
    );

    dpa_signmag #(.W(HALF_W)) i_signmag (
        .lhs     (a_q),
        .rhs     (mem_word),
        .lhs_mag (mag_a),
        .rhs_mag (mag_m),
        .neg     (mul_neg)
    );

    dpa_mul_seq #(.FLD(FLD)) i_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mul_load),
        .mcand  (mag_a),
        .mplier (mag_m),
        .step   (mul_step),
        .prod   (prod),
        .last   (mul_last)
    );

    assign mul_res = neg_q ? (VW'(0) - {1'b0, prod}) : {1'b0, prod};

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_LOAD;
            hi_q  <= '0;
            lo_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            ovf_q <= 1'b0;
            neg_q <= 1'b0;
        end else begin
            if (accept_start) begin
                op_q <= dpa_op_e'(op_sel);
            end
            if (cap_hi) begin
                hi_q <= mem_word;
            end
            if (mul_load) begin
                neg_q <= mul_neg;
            end
            if (cap_lo) begin
                lo_q <= mem_word;
            end
            if (wr_combine) begin
                unique case (op_q)
                    OP_LOAD: begin
                        a_q   <= hi_q;
                        b_q   <= lo_q;
                        ovf_q <= 1'b0;
                    end
                    OP_ADD, OP_SUB: begin
                        a_q   <= as_res[VW-1:FLD];
                        b_q   <= {1'b0, as_res[FLD-1:0]};
                        ovf_q <= as_ovf;
                    end
                    default: begin
                        a_q   <= a_q;
                        b_q   <= b_q;
                        ovf_q <= ovf_q;
                    end
                endcase
            end
            if (wr_mul) begin
                a_q   <= mul_res[VW-1:FLD];
                b_q   <= {1'b0, mul_res[FLD-1:0]};
                ovf_q <= 1'b0;
            end
        end
    end

    assign a_out = a_q;
    assign b_out = b_q;
    assign ovf   = ovf_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3 R4 R6
    bmsb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q != OP_LOAD) |-> !b_out[HALF_W-1]);

    // R5
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (op_q == OP_ADD || op_q == OP_SUB));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMBINE && state_q != ST_MUL_FIX) |=>
            ($stable(a_out) && $stable(b_out)));

    // R8
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_RUN && start) |=> (state_q != ST_GET_HI));
endmodule

// File: tb/test_dpa_core.sv
module test_dpa_core;
    localparam int W   = 4;
    localparam int FLD = W - 1;
    localparam int VW  = 2 * W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         mem_valid = 1'b0;
    logic [W-1:0] mem_word = '0;
    logic [W-1:0] a_out, b_out;
    logic         ovf, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dpa_core #(.HALF_W(W)) i_dpa_core (
        .clk, .rst_n, .start, .op_sel, .mem_valid, .mem_word,
        .a_out, .b_out, .ovf, .done
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one operation; returns cycles from first word to done.
    task automatic do_op(input logic [1:0] op, input logic [W-1:0] hi,
                         input logic [W-1:0] lo, output int lat);
        @(negedge clk);
        start = 1'b1; op_sel = op;
        @(negedge clk);
        start = 1'b0; mem_valid = 1'b1; mem_word = hi; lat = 0;
        @(negedge clk);
        lat = 1;
        if (op != 2'b11) begin
            mem_word = lo;
            @(negedge clk);
            lat = 2;
        end
        mem_valid = 1'b0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic int sval(input logic [VW-1:0] v);
        int s;
        s = int'(v);
        if (v[VW-1]) s = s - (1 << VW);
        return s;
    endfunction

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 a", int'(a_out), 0);
        chk("R1 b", int'(b_out), 0);
        chk("R1 ovf", int'(ovf), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;

        // R2 load every raw A:B pattern
        for (int v = 0; v < 256; v++) begin
            do_op(2'b00, v[7:4], v[3:0], lat);
            chk("R2 a", int'(a_out), v >> 4);
            chk("R2 b", int'(b_out), v & 15);
            chk("R5 load ovf", int'(ovf), 0);
            chk("R7 load latency", lat, 3);
        end

        // R3 R4 R5 add/subtract sweeps
        for (int op = 1; op <= 2; op++) begin
            for (int x = 0; x < 128; x += 5) begin
                for (int y = 0; y < 128; y++) begin
                    logic [VW-1:0] xv, yv, rv;
                    int sum, expo;
                    xv = x[VW-1:0]; yv = y[VW-1:0];
                    do_op(2'b00, xv[VW-1:FLD], {y[0], xv[FLD-1:0]}, lat);
                    do_op(op[1:0], yv[VW-1:FLD], {x[1] ^ y[2], yv[FLD-1:0]}, lat);
                    sum = (op == 1) ? sval(xv) + sval(yv) : sval(xv) - sval(yv);
                    expo = (sum > 63 || sum < -64) ? 1 : 0;
                    rv = sum[VW-1:0];
                    if (op == 1) begin
                        chk("R3 a", int'(a_out), int'(rv[VW-1:FLD]));
                        chk("R3 b", int'(b_out), int'(rv[FLD-1:0]));
                    end else begin
                        chk("R4 a", int'(a_out), int'(rv[VW-1:FLD]));
                        chk("R4 b", int'(b_out), int'(rv[FLD-1:0]));
                    end
                    chk("R5 ovf", int'(ovf), expo);
                    chk("R7 addsub latency", lat, 3);
                end
            end
        end

        // R6 multiply over all operand pairs
        for (int p = -8; p < 8; p++) begin
            for (int q = -8; q < 8; q++) begin
                int ma, mq, pr;
                logic [VW-1:0] rv;
                ma = (p < 0 ? -p : p) % 8;
                mq = (q < 0 ? -q : q) % 8;
                pr = ma * mq;
                if ((p < 0) != (q < 0)) pr = -pr;
                rv = pr[VW-1:0];
                do_op(2'b00, p[W-1:0], 4'hF, lat);
                do_op(2'b11, q[W-1:0], 4'h0, lat);
                chk("R6 a", int'(a_out), int'(rv[VW-1:FLD]));
                chk("R6 b", int'(b_out), int'(rv[FLD-1:0]));
                chk("R5 mul ovf", int'(ovf), 0);
                chk("R7 mul latency", lat, W + 1);
            end
        end

        // R8 words offered while idle are ignored
        do_op(2'b00, 4'h5, 4'hA, lat);
        @(negedge clk);
        mem_valid = 1'b1; mem_word = 4'h3;
        repeat (4) @(negedge clk);
        mem_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle a", int'(a_out), 5);
        chk("R8 idle b", int'(b_out), 10);

        // R8 start during a multiply is ignored
        do_op(2'b00, 4'h3, 4'h0, lat);
        @(negedge clk);
        start = 1'b1; op_sel = 2'b11;
        @(negedge clk);
        start = 1'b0; mem_valid = 1'b1; mem_word = 4'h2;
        @(negedge clk);
        mem_valid = 1'b0; start = 1'b1; op_sel = 2'b00;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        chk("R8 busy a", int'(a_out), 0);
        chk("R8 busy b", int'(b_out), 6);
        repeat (3) @(negedge clk);
        do_op(2'b00, 4'h9, 4'hC, lat);
        chk("R8 follow-on a", int'(a_out), 9);
        chk("R8 follow-on b", int'(b_out), 12);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule